// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, a 16-bit segment selector plus an offset, into a linear address. It has two ways of finding the segment base. In real mode the base is the selector shifted left by four bits. The sum is kept inside a 20-bit space and is marked as final, so no later translation stage is needed. In protected mode the selector picks an entry from one of two small descriptor tables, the global one or the local one. The entry supplies a 32-bit base and a 20-bit limit. An offset past the limit raises a fault in place of a result.

A request may carry its selector explicitly. It may instead name one of four stored segment registers: code, data, stack or extra. Software fills the descriptor tables and the segment registers through two write ports. Only one request is in flight at a time, and its result is registered one clock later.

Top module: `seg_xlate_top`

## Requirements
- R1: In real mode (`req_prot`=0) the result is (selector × 16 + `req_ofs[15:0]`) modulo 2^20, placed in `lin_addr[19:0]`, with `lin_addr[31:20]` zero. Offset bits 31:16 have no effect.
- R2: A real-mode request never faults. Its result has `lin_vld`=1 and `lin_final`=1.
- R3: In protected mode the table index is selector bits [15:3], and selector bit 2 picks the table (0 global, 1 local). Selector bits [1:0] have no effect. The result is (entry base + `req_ofs`) modulo 2^32.
- R4: In protected mode, an offset greater than the entry limit gives `lin_fault`=1, `lin_vld`=0 and `lin_addr`=0. An offset equal to the limit is valid.
- R5: A protected-mode index of 8 or more, beyond the table depth, gives a fault the same way as R4.
- R6: With `req_use_sel`=1 the selector is `req_sel`. With `req_use_sel`=0 it is the segment register numbered `req_sreg` (0 code, 1 data, 2 stack, 3 extra).
- R7: `lin_vld`, `lin_fault` and `lin_final` pulse for exactly the one cycle that follows a cycle with `req_vld`=1. In any other cycle all outputs are zero, including `lin_addr`.
- R8: After reset all outputs are zero, every segment register holds 0, and every descriptor entry has base 0 and limit 0.
- R9: A descriptor write (`cfg_*`) or segment-register write (`sreg_*`) is seen by requests in later cycles. A request in the same cycle as the write still sees the old content.
- R10: A protected-mode result never asserts `lin_final`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_tbl | input | 1 | Table to write: 0 global, 1 local |
| cfg_idx | input | 3 | Entry number to write |
| cfg_base | input | 32 | Segment base to store |
| cfg_limit | input | 20 | Segment limit to store |
| sreg_we | input | 1 | Segment-register write strobe |
| sreg_wr_idx | input | 2 | Segment register to write |
| sreg_wr_val | input | 16 | Selector value to store |
| req_vld | input | 1 | Translation request strobe |
| req_prot | input | 1 | Mode: 0 real, 1 protected |
| req_use_sel | input | 1 | 1: use `req_sel`; 0: use a stored segment register |
| req_sel | input | 16 | Explicit segment selector |
| req_sreg | input | 2 | Stored segment register to use |
| req_ofs | input | 32 | Offset within the segment |
| lin_addr | output | 32 | Linear address result |
| lin_vld | output | 1 | Result valid pulse |
| lin_fault | output | 1 | Limit or index fault pulse |
| lin_final | output | 1 | Result needs no further translation (real mode) |

## Verification
Every result, whether an address, a fault or the final marker, is due in the cycle right after the request strobe. In every other cycle the outputs must be all zero. The bench computes the expected outputs from its own model before the rising edge that captures the request. It applies any table or register writes to the model only after that edge, which gives the old-content rule of R9. It then compares all four outputs at the next falling edge. Idle cycles are compared in the same way, so a late, early or stretched pulse is caught.

// File: rtl/seg_xlate_pkg.sv
// Shared constants and types for the segmented address translator.
// Assumes a 16-bit selector whose index field starts at bit 3.
package seg_xlate_pkg;
    localparam int unsigned SEL_W      = 16;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned LIM_W      = 20;
    localparam int unsigned REAL_W     = 20;
    localparam int unsigned REAL_OFS_W = 16;
    localparam int unsigned REAL_SHIFT = 4;
    localparam int unsigned IDX_LSB    = 3;
    localparam int unsigned TI_BIT     = 2;
    localparam int unsigned FULL_IDX_W = SEL_W - IDX_LSB;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
    } seg_desc_t;

    typedef enum logic {
        TBL_GLOBAL = 1'b0,
        TBL_LOCAL  = 1'b1
    } seg_tbl_e;
endpackage

// File: rtl/seg_sel_file.sv
// Stored segment selector registers (code, data, stack, extra, ...).
// One write port, one combinational read port; reset clears all to 0.
// A read in the cycle of a write returns the old value.
module seg_sel_file
    import seg_xlate_pkg::*;
#(
    parameter  int unsigned NUM_SREG = 4,
    localparam int unsigned SR_W     = $clog2(NUM_SREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SR_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0] wr_val,
    input  logic [SR_W-1:0]  rd_idx,
    output logic [SEL_W-1:0] rd_val
);
    logic [SEL_W-1:0] regs [NUM_SREG];

    for (genvar i = 0; i < NUM_SREG; i++) begin : g_reg
        // Hold one selector; load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && (wr_idx == SR_W'(i)))
                regs[i] <= wr_val;
        end
    end

    // Read the addressed selector.
    always_comb rd_val = regs[rd_idx];
endmodule

// File: rtl/seg_desc_table.sv
// One descriptor table: DEPTH entries of base and limit.
// Write port for configuration, combinational read for translation.
// Reset clears every entry to base 0, limit 0.
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_desc_t        wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_desc_t        rd_desc
);
    seg_desc_t entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Hold one descriptor; load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[i] <= '0;
            else if (we && (wr_idx == IDX_W'(i)))
                entry[i] <= wr_desc;
        end
    end

    // Read the addressed descriptor.
    always_comb rd_desc = entry[rd_idx];
endmodule

// File: rtl/seg_addr_calc.sv
// Combinational base derivation and address sum.
// Real mode: selector scaled by 16, plus low offset, wrapped to 20 bits.
// Protected mode: descriptor chosen by the table bit, index range and
// limit checked, base plus full offset wrapped to 32 bits.
module seg_addr_calc
    import seg_xlate_pkg::*;
#(
    parameter int unsigned TBL_DEPTH = 8
) (
    input  logic              prot,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] ofs,
    input  seg_desc_t         gdesc,
    input  seg_desc_t         ldesc,
    output logic [ADDR_W-1:0] addr,
    output logic              fault
);
    logic [REAL_W-1:0]     real_sum;
    logic [FULL_IDX_W-1:0] idx_full;
    logic                  idx_ok;
    seg_desc_t             desc;
    logic                  over_lim;

    // Real-mode path: scaled selector plus 16-bit offset, carry dropped.
    always_comb real_sum = REAL_W'({sel, {REAL_SHIFT{1'b0}}})
                         + REAL_W'(ofs[REAL_OFS_W-1:0]);

    // Protected-mode path: pick table, check index and limit.
    always_comb begin
        idx_full = sel[SEL_W-1:IDX_LSB];
        idx_ok   = idx_full < FULL_IDX_W'(TBL_DEPTH);
        desc     = (seg_tbl_e'(sel[TI_BIT]) == TBL_LOCAL) ? ldesc : gdesc;
        over_lim = ofs > {{(ADDR_W-LIM_W){1'b0}}, desc.limit};
    end

    // Select the mode's result and fault.
    always_comb begin
        if (prot) begin
            addr  = desc.base + ofs;
            fault = !idx_ok || over_lim;
        end else begin
            addr  = {{(ADDR_W-REAL_W){1'b0}}, real_sum};
            fault = 1'b0;
        end
    end
endmodule

// File: rtl/seg_xlate_top.sv
// Segmented logical-to-linear address translator, top level.
// Assumes at most one request in flight; result registered one clock
// after req_vld. Outputs are zero in cycles without a result.
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter  int unsigned TBL_DEPTH = 8,
    parameter  int unsigned NUM_SREG  = 4,
    localparam int unsigned IDX_W     = $clog2(TBL_DEPTH),
    localparam int unsigned SR_W      = $clog2(NUM_SREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic              sreg_we,
    input  logic [SR_W-1:0]   sreg_wr_idx,
    input  logic [SEL_W-1:0]  sreg_wr_val,
    input  logic              req_vld,
    input  logic              req_prot,
    input  logic              req_use_sel,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [SR_W-1:0]   req_sreg,
    input  logic [ADDR_W-1:0] req_ofs,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              lin_vld,
    output logic              lin_fault,
    output logic              lin_final
);
    localparam int unsigned NUM_TBL = 2;

    logic [SEL_W-1:0]  sreg_val;
    logic [SEL_W-1:0]  sel;
    seg_desc_t         rd_desc [NUM_TBL];
    seg_desc_t         wr_desc;
    logic [ADDR_W-1:0] calc_addr;
    logic              calc_fault;

    seg_sel_file #(.NUM_SREG(NUM_SREG)) u_sregs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sreg_we),
        .wr_idx (sreg_wr_idx),
        .wr_val (sreg_wr_val),
        .rd_idx (req_sreg),
        .rd_val (sreg_val)
    );

    // Choose the explicit selector or a stored one.
    always_comb sel = req_use_sel ? req_sel : sreg_val;

    // Pack the configuration write data.
    always_comb wr_desc = '{base: cfg_base, limit: cfg_limit};

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        seg_desc_table #(.DEPTH(TBL_DEPTH)) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (cfg_we && (cfg_tbl == 1'(t))),
            .wr_idx  (cfg_idx),
            .wr_desc (wr_desc),
            .rd_idx  (sel[IDX_LSB +: IDX_W]),
            .rd_desc (rd_desc[t])
        );
    end

    seg_addr_calc #(.TBL_DEPTH(TBL_DEPTH)) u_calc (
        .prot  (req_prot),
        .sel   (sel),
        .ofs   (req_ofs),
        .gdesc (rd_desc[TBL_GLOBAL]),
        .ldesc (rd_desc[TBL_LOCAL]),
        .addr  (calc_addr),
        .fault (calc_fault)
    );

    // Register the result for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_addr  <= '0;
            lin_vld   <= 1'b0;
            lin_fault <= 1'b0;
            lin_final <= 1'b0;
        end else begin
            lin_vld   <= req_vld && !calc_fault;
            lin_fault <= req_vld && calc_fault;
            lin_final <= req_vld && !req_prot;
            lin_addr  <= (req_vld && !calc_fault) ? calc_addr : '0;
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
// Property checker for seg_xlate_top, attached by bind below.
// Relates request inputs to the registered results one cycle later.
module seg_xlate_chk
    import seg_xlate_pkg::*;
#(
    parameter int unsigned TBL_DEPTH = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_vld,
    input logic                  req_prot,
    input logic                  req_use_sel,
    input logic [SEL_W-1:0]      req_sel,
    input logic [REAL_OFS_W-1:0] req_ofs_lo,
    input logic [ADDR_W-1:0]     lin_addr,
    input logic                  lin_vld,
    input logic                  lin_fault,
    input logic                  lin_final
);
    a_r7_result_due: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (lin_vld || lin_fault));

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_vld || lin_fault || lin_final) |-> $past(req_vld));

    a_r7_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_vld |-> (lin_addr == '0));

    a_r4_vld_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lin_vld && lin_fault));

    a_r2_real_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        lin_fault |-> $past(req_prot));

    a_r2_real_final: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_vld && !req_prot) |-> (lin_vld && lin_final));

    a_r10_prot_not_final: assert property (@(posedge clk) disable iff (!rst_n)
        lin_final |-> !$past(req_prot));

    a_r1_real_range: assert property (@(posedge clk) disable iff (!rst_n)
        lin_final |-> (lin_addr[ADDR_W-1:REAL_W] == '0));

    a_r1_real_sum: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_vld && !req_prot && req_use_sel) |->
        (lin_addr[REAL_W-1:0] ==
         REAL_W'({$past(req_sel), 4'b0000} + {4'b0000, $past(req_ofs_lo)})));

    a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_vld && req_prot && req_use_sel &&
              (req_sel[SEL_W-1:IDX_LSB] >= FULL_IDX_W'(TBL_DEPTH)))
        |-> lin_fault);
endmodule

bind seg_xlate_top seg_xlate_chk #(.TBL_DEPTH(TBL_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (req_vld),
    .req_prot    (req_prot),
    .req_use_sel (req_use_sel),
    .req_sel     (req_sel),
    .req_ofs_lo  (req_ofs[15:0]),
    .lin_addr    (lin_addr),
    .lin_vld     (lin_vld),
    .lin_fault   (lin_fault),
    .lin_final   (lin_final)
);

// File: tb/tb_seg_xlate_top.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural reference model, compared every clock.
module tb_seg_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_tbl;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_base;
    logic [19:0] cfg_limit;
    logic        sreg_we;
    logic [1:0]  sreg_wr_idx;
    logic [15:0] sreg_wr_val;
    logic        req_vld, req_prot, req_use_sel;
    logic [15:0] req_sel;
    logic [1:0]  req_sreg;
    logic [31:0] req_ofs;
    logic [31:0] lin_addr;
    logic        lin_vld, lin_fault, lin_final;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    logic [31:0] m_base [2][8];
    logic [19:0] m_lim  [2][8];
    logic [15:0] m_sreg [4];

    always #10 clk = ~clk;

    seg_xlate_top dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .sreg_we(sreg_we), .sreg_wr_idx(sreg_wr_idx), .sreg_wr_val(sreg_wr_val),
        .req_vld(req_vld), .req_prot(req_prot), .req_use_sel(req_use_sel),
        .req_sel(req_sel), .req_sreg(req_sreg), .req_ofs(req_ofs),
        .lin_addr(lin_addr), .lin_vld(lin_vld), .lin_fault(lin_fault),
        .lin_final(lin_final)
    );

    task automatic idle();
        cfg_we = 0; cfg_tbl = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0;
        sreg_we = 0; sreg_wr_idx = 0; sreg_wr_val = 0;
        req_vld = 0; req_prot = 0; req_use_sel = 0; req_sel = 0;
        req_sreg = 0; req_ofs = 0;
    endtask

    task automatic set_req(input logic prot, input logic use_sel,
                           input logic [15:0] sel, input logic [1:0] sr,
                           input logic [31:0] ofs);
        req_vld = 1; req_prot = prot; req_use_sel = use_sel;
        req_sel = sel; req_sreg = sr; req_ofs = ofs;
    endtask

    task automatic set_cfg(input logic tbl, input logic [2:0] idx,
                           input logic [31:0] base, input logic [19:0] lim);
        cfg_we = 1; cfg_tbl = tbl; cfg_idx = idx; cfg_base = base; cfg_limit = lim;
    endtask

    task automatic set_sreg(input logic [1:0] idx, input logic [15:0] val);
        sreg_we = 1; sreg_wr_idx = idx; sreg_wr_val = val;
    endtask

    // One clock: predict, let the edge happen, update model, compare.
    task automatic tick(input string tag);
        logic [31:0] e_addr = 0;
        logic e_vld = 0, e_fault = 0, e_final = 0;
        logic [15:0] s;
        int unsigned ix;
        if (req_vld) begin
            s = req_use_sel ? req_sel : m_sreg[req_sreg];
            if (!req_prot) begin
                e_vld = 1; e_final = 1;
                e_addr = (int'(s) * 16 + int'(req_ofs[15:0])) % (1 << 20);
            end else begin
                ix = int'(s) / 8;
                if (ix >= 8) e_fault = 1;
                else if (req_ofs > {12'b0, m_lim[s[2]][ix]}) e_fault = 1;
                else begin
                    e_vld = 1;
                    e_addr = m_base[s[2]][ix] + req_ofs;
                end
            end
        end
        @(posedge clk);
        if (cfg_we) begin
            m_base[cfg_tbl][cfg_idx] = cfg_base;
            m_lim[cfg_tbl][cfg_idx]  = cfg_limit;
        end
        if (sreg_we) m_sreg[sreg_wr_idx] = sreg_wr_val;
        @(negedge clk);
        n_tests++;
        if (lin_addr !== e_addr || lin_vld !== e_vld ||
            lin_fault !== e_fault || lin_final !== e_final) begin
            n_fail++;
            $display("FAIL %s: addr=%h vld=%b fault=%b final=%b, expected addr=%h vld=%b fault=%b final=%b",
                     tag, lin_addr, lin_vld, lin_fault, lin_final,
                     e_addr, e_vld, e_fault, e_final);
        end
        idle();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 8; i++) begin m_base[t][i] = 0; m_lim[t][i] = 0; end
        for (int i = 0; i < 4; i++) m_sreg[i] = 0;
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R8: outputs zero after reset
        n_tests++;
        if (lin_addr !== 0 || lin_vld !== 0 || lin_fault !== 0 || lin_final !== 0) begin
            n_fail++;
            $display("FAIL R8 reset outputs addr=%h vld=%b fault=%b final=%b, expected all 0",
                     lin_addr, lin_vld, lin_fault, lin_final);
        end
        // R8: reset descriptor (base 0, limit 0) and reset segment register
        set_req(1, 1, 16'h0000, 0, 0);          tick("R8 desc reset ofs0");
        set_req(1, 1, 16'h000C, 0, 1);          tick("R8 desc reset ofs1 fault");
        set_req(0, 0, 16'h7777, 2, 32'h10);     tick("R8 sreg reset");
        tick("R7 idle");

        // R1/R2: real mode
        set_req(0, 1, 16'h1234, 0, 32'h0010);     tick("R1 basic");
        set_req(0, 1, 16'hFFFF, 0, 32'h0000FFFF); tick("R1 wrap 20 bit");
        set_req(0, 1, 16'h0000, 0, 32'hABCD0005); tick("R1 upper offset ignored");
        set_req(0, 1, 16'hF000, 0, 32'hFFFFFFFF); tick("R2 real never faults");
        tick("R7 idle after real");

        // Load descriptor tables
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 8; i++) begin
                set_cfg(t[0], i[2:0], 32'h0010_0000 * (i + 1) + 32'h0800_0000 * t,
                        20'h00FFF + 20'h01000 * i + 20'h00100 * t);
                tick("R9 load");
            end

        // R3/R4/R10: protected mode
        set_req(1, 1, 16'h0013, 0, 32'h00002FFF);   tick("R3 global idx2 rpl ignored, R4 ofs==limit");
        set_req(1, 1, 16'h0010, 0, 32'h00003000);   tick("R4 ofs limit+1 fault");
        set_req(1, 1, 16'h002C, 0, 32'h00000123);   tick("R3 local idx5 R10");
        set_req(1, 1, 16'h002F, 0, 32'h00000123);   tick("R3 local idx5 rpl3");
        set_req(1, 1, 16'h0040, 0, 32'h0);          tick("R5 index 8 fault");
        set_req(1, 1, 16'hFFFF, 0, 32'h0);          tick("R5 index max fault");
        set_req(1, 1, 16'h0008, 0, 32'h80000000);   tick("R4 huge offset fault");
        set_cfg(0, 7, 32'hFFFFF000, 20'hFFFFF);     tick("R9 load wrap desc");
        set_req(1, 1, 16'h0038, 0, 32'h00002000);   tick("R3 32-bit wrap");

        // R9: same-cycle write sees old content
        set_cfg(0, 1, 32'h4000_0000, 20'h0000F);
        set_req(1, 1, 16'h0008, 0, 32'h00000010);   tick("R9 same-cycle old desc");
        set_req(1, 1, 16'h0008, 0, 32'h00000010);   tick("R9 new desc limit fault");
        set_req(1, 1, 16'h0008, 0, 32'h0000000F);   tick("R9 new desc valid");

        // R6: stored segment registers
        set_sreg(0, 16'h0008); set_req(0, 0, 0, 0, 32'h4); tick("R6 R9 same-cycle sreg old");
        set_sreg(1, 16'h0014); tick("R6 write data");
        set_sreg(2, 16'h0024); tick("R6 write stack");
        set_sreg(3, 16'hB800); tick("R6 write extra");
        for (int k = 0; k < 4; k++) begin
            set_req(1, 0, 16'hFFFF, k[1:0], 32'h00000005); tick("R6 prot sreg");
            set_req(0, 0, 16'hFFFF, k[1:0], 32'h00000005); tick("R6 real sreg");
        end

        // Mixed random traffic
        for (int n = 0; n < 600; n++) begin
            int unsigned r = $urandom_range(0, 9);
            if (r == 0) begin
                set_cfg($urandom_range(0, 1), $urandom_range(0, 7), $urandom, $urandom);
            end else if (r == 1) begin
                set_sreg($urandom_range(0, 3),
                         {3'($urandom_range(0, 1)), 13'($urandom)} & 16'h004F);
            end
            if (r >= 3) begin
                logic [15:0] s = {13'($urandom_range(0, 9)), 3'($urandom)};
                logic [31:0] o = ($urandom_range(0, 1) == 1) ? 32'($urandom) : 32'($urandom_range(0, 32'h000FFFFF));
                set_req($urandom_range(0, 1), $urandom_range(0, 1), s,
                        $urandom_range(0, 3), o);
            end
            tick("R7 random mix");
        end
        tick("R7 final idle");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule